// File: doc/BRIEF.md
# System Control Fault Register Bank

This block is a bank of memory-mapped system-control registers for a small processor core. It is reached over a simple 32-bit register bus that has a write strobe, a byte offset and a privilege flag. Reads are combinational on the presented offset. The bank holds six registers:

- a configuration word in which only six bits can be written;
- three sticky fault status words, which hardware fault-event inputs set and software clears by writing ones;
- two plain fault address words;
- a write-only trigger that software uses to raise an interrupt.

A write to the trigger that is accepted produces a pending-set pulse to the interrupt controller. The pulse lasts one cycle and carries the interrupt number. Unprivileged code may use the trigger only when the configuration word allows it. The bank does not do interrupt prioritisation or exception sequencing.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, every register reads as zero and `pend_valid` is low.
- R2: A write to offset 0xD14 keeps only bits 9, 8, 4, 3, 1 and 0 of the data (mask 0x31B). Every other bit of that register reads as zero.
- R3: A write to offset 0xD28, 0xD2C or 0xD30 clears each status bit for which the write data holds a 1. Status bits written with 0 keep their value.
- R4: A 1 on bit i of `cfg_fault_set`, `hard_fault_set` or `dbg_fault_set` sets bit i of the status register at 0xD28, 0xD2C or 0xD30 respectively on the next clock edge. If software clears the same bit in the same cycle, the set wins.
- R5: Offsets 0xD34 and 0xD38 are plain 32-bit read/write registers.
- R6: An accepted write to offset 0xF00 drives `pend_valid` high in the following cycle. In that cycle `pend_irq` equals write data bits [8:0]. A write whose number is not below `NUM_IRQ` produces no pulse.
- R7: A write to 0xF00 with `bus_priv` low is ignored unless bit 1 of the configuration register is 1. A write with `bus_priv` high is always accepted, subject to the range check of R6.
- R8: Offset 0xF00, every unmapped offset and every offset with bits [1:0] not zero read as zero. Writes to unmapped offsets change no register.
- R9: Each accepted trigger write produces `pend_valid` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cfg_fault_set | input | 32 | Set vector for the configurable fault status register |
| hard_fault_set | input | 32 | Set vector for the hard fault status register |
| dbg_fault_set | input | 32 | Set vector for the debug fault status register |
| pend_valid | output | 1 | One-cycle pending-set pulse |
| pend_irq | output | 9 | Interrupt number carried by the pulse |

## Verification
The bench drives a hardware set and a software clear onto the same status bit in the same cycle. A design in which the clear wins would lose a fault that arrived during the clear. It writes trigger numbers just below and just at `NUM_IRQ`, and a word whose upper bits are set. An off-by-one range check would pulse for interrupt 64, and a design that does not truncate to nine bits would drop the write or report the wrong number. It sends unprivileged trigger writes with the permission bit both clear and set. A missing gate would pulse when it should not, and a gate that ignores the permission bit would never pulse. It also writes all ones to the configuration word and to an unmapped offset, and reads back whatever a wrong mask or a wrong decode would have let through.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CFG      = 12'hD14;
    localparam logic [ADDR_W-1:0] OFF_FLT_CFG  = 12'hD28;
    localparam logic [ADDR_W-1:0] OFF_FLT_HARD = 12'hD2C;
    localparam logic [ADDR_W-1:0] OFF_FLT_DBG  = 12'hD30;
    localparam logic [ADDR_W-1:0] OFF_MEM_ADDR = 12'hD34;
    localparam logic [ADDR_W-1:0] OFF_BUS_ADDR = 12'hD38;
    localparam logic [ADDR_W-1:0] OFF_TRIG     = 12'hF00;

    // writable fields of the configuration word
    localparam int BIT_STK_ALIGN  = 9;
    localparam int BIT_IGN_FAULT  = 8;
    localparam int BIT_DIV0_TRAP  = 4;
    localparam int BIT_UNAL_TRAP  = 3;
    localparam int BIT_USER_TRIG  = 1;
    localparam int BIT_NONBASE_EN = 0;

    localparam logic [DATA_W-1:0] CFG_MASK =
        (DATA_W'(1) << BIT_STK_ALIGN) | (DATA_W'(1) << BIT_IGN_FAULT) |
        (DATA_W'(1) << BIT_DIV0_TRAP) | (DATA_W'(1) << BIT_UNAL_TRAP) |
        (DATA_W'(1) << BIT_USER_TRIG) | (DATA_W'(1) << BIT_NONBASE_EN);

    localparam int NUM_FLT = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_FLT_CFG,
        SEL_FLT_HARD,
        SEL_FLT_DBG,
        SEL_MEM_ADDR,
        SEL_BUS_ADDR,
        SEL_TRIG
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] mem_addr;
        logic [DATA_W-1:0] bus_addr;
    } bank_st_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (addr[ADDR_W-1:2])
                OFF_CFG[ADDR_W-1:2]:      sel = SEL_CFG;
                OFF_FLT_CFG[ADDR_W-1:2]:  sel = SEL_FLT_CFG;
                OFF_FLT_HARD[ADDR_W-1:2]: sel = SEL_FLT_HARD;
                OFF_FLT_DBG[ADDR_W-1:2]:  sel = SEL_FLT_DBG;
                OFF_MEM_ADDR[ADDR_W-1:2]: sel = SEL_MEM_ADDR;
                OFF_BUS_ADDR[ADDR_W-1:2]: sel = SEL_BUS_ADDR;
                OFF_TRIG[ADDR_W-1:2]:     sel = SEL_TRIG;
                default:                  sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_sticky.sv
module sysctl_sticky #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.bits = st_d.bits & ~clr_mask;
        end
        // hardware events applied after the clear so they take precedence
        st_d.bits = st_d.bits | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val = st_q.bits;
endmodule

// File: rtl/sysctl_swtrig.sv
module sysctl_swtrig #(
    parameter int NUM_IRQ = 64,
    parameter int IRQ_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             priv,
    input  logic             user_ok,
    input  logic [IRQ_W-1:0] num,
    output logic             pend_valid,
    output logic [IRQ_W-1:0] pend_irq
);
    localparam logic [IRQ_W:0] LIMIT = (IRQ_W+1)'(NUM_IRQ);

    typedef struct packed {
        logic             vld;
        logic [IRQ_W-1:0] irq;
    } st_t;

    st_t  st_d, st_q;
    logic in_range;
    logic allowed;

    always_comb begin
        in_range = ({1'b0, num} < LIMIT);
        allowed  = priv || user_ok;
        st_d     = '0;
        if (wr && allowed && in_range) begin
            st_d.vld = 1'b1;
            st_d.irq = num;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_valid = st_q.vld;
    assign pend_irq   = st_q.irq;
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int IRQ_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cfg_fault_set,
    input  logic [DATA_W-1:0] hard_fault_set,
    input  logic [DATA_W-1:0] dbg_fault_set,
    output logic              pend_valid,
    output logic [IRQ_W-1:0]  pend_irq
);
    sel_e              sel;
    bank_st_t          st_d, st_q;
    logic [DATA_W-1:0] flt_set [NUM_FLT];
    logic [DATA_W-1:0] flt_val [NUM_FLT];
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] flt_cfg_q;
    logic              trig_wr;

    sysctl_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign flt_set[0] = cfg_fault_set;
    assign flt_set[1] = hard_fault_set;
    assign flt_set[2] = dbg_fault_set;

    for (genvar gi = 0; gi < NUM_FLT; gi++) begin : g_flt
        localparam sel_e MY_SEL = (gi == 0) ? SEL_FLT_CFG :
                                  (gi == 1) ? SEL_FLT_HARD : SEL_FLT_DBG;
        logic clr_en;
        assign clr_en = bus_wen && (sel == MY_SEL);
        sysctl_sticky #(.W(DATA_W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_en   (clr_en),
            .clr_mask (bus_wdata),
            .set_vec  (flt_set[gi]),
            .val      (flt_val[gi])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wen) begin
            unique case (sel)
                SEL_CFG:      st_d.cfg      = bus_wdata & CFG_MASK;
                SEL_MEM_ADDR: st_d.mem_addr = bus_wdata;
                SEL_BUS_ADDR: st_d.bus_addr = bus_wdata;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q     = st_q.cfg;
    assign flt_cfg_q = flt_val[0];
    assign trig_wr   = bus_wen && (sel == SEL_TRIG);

    sysctl_swtrig #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (trig_wr),
        .priv       (bus_priv),
        .user_ok    (cfg_q[BIT_USER_TRIG]),
        .num        (bus_wdata[IRQ_W-1:0]),
        .pend_valid (pend_valid),
        .pend_irq   (pend_irq)
    );

    always_comb begin
        unique case (sel)
            SEL_CFG:      bus_rdata = st_q.cfg;
            SEL_FLT_CFG:  bus_rdata = flt_val[0];
            SEL_FLT_HARD: bus_rdata = flt_val[1];
            SEL_FLT_DBG:  bus_rdata = flt_val[2];
            SEL_MEM_ADDR: bus_rdata = st_q.mem_addr;
            SEL_BUS_ADDR: bus_rdata = st_q.bus_addr;
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int IRQ_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_priv,
    input logic [DATA_W-1:0] cfg_fault_set,
    input logic [DATA_W-1:0] cfg_ctrl,
    input logic [DATA_W-1:0] flt_cfg,
    input logic              pend_valid,
    input logic [IRQ_W-1:0]  pend_irq
);
    localparam logic [IRQ_W:0] LIMIT = (IRQ_W+1)'(NUM_IRQ);

    logic seen_q;
    logic hit_cfg, hit_flt, hit_trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign hit_cfg  = bus_wen && (bus_addr == OFF_CFG);
    assign hit_flt  = bus_wen && (bus_addr == OFF_FLT_CFG);
    assign hit_trig = bus_wen && (bus_addr == OFF_TRIG);

    // R2
    cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(hit_cfg)) |-> (cfg_ctrl == ($past(bus_wdata) & CFG_MASK)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(hit_flt)) |->
        (flt_cfg == (($past(flt_cfg) & ~$past(bus_wdata)) | $past(cfg_fault_set))));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (($past(cfg_fault_set) & ~flt_cfg) == '0));

    // R6
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (seen_q && $past(hit_trig) &&
                        pend_irq == $past(bus_wdata[IRQ_W-1:0])));

    // R6
    pend_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ({1'b0, pend_irq} < LIMIT));

    // R7
    pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> $past(bus_priv || cfg_ctrl[BIT_USER_TRIG]));
endmodule

bind sysctl_bank sysctl_bank_chk #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wen       (bus_wen),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_priv      (bus_priv),
    .cfg_fault_set (cfg_fault_set),
    .cfg_ctrl      (cfg_q),
    .flt_cfg       (flt_cfg_q),
    .pend_valid    (pend_valid),
    .pend_irq      (pend_irq)
);

// File: tb/tb_sysctl_bank.sv
`timescale 1ns/1ps
module tb_sysctl_bank;
    localparam int NUM_IRQ = 64;
    localparam int IRQ_W   = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] cfg_fault_set = '0;
    logic [31:0] hard_fault_set = '0;
    logic [31:0] dbg_fault_set = '0;
    logic        pend_valid;
    logic [8:0]  pend_irq;

    int checks = 0;
    int errs   = 0;

    always #4 clk = ~clk;

    sysctl_bank #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
        .cfg_fault_set(cfg_fault_set), .hard_fault_set(hard_fault_set),
        .dbg_fault_set(dbg_fault_set), .pend_valid(pend_valid), .pend_irq(pend_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'hD14, 32'hFFFF_FFFF, 4'd2},  // R2 write all ones
        '{1'b0, 12'hD14, 32'h0000_031B, 4'd2},  // R2 only six bits stick
        '{1'b1, 12'hD14, 32'h0000_0A5A, 4'd2},
        '{1'b0, 12'hD14, 32'h0000_021A, 4'd2},
        '{1'b1, 12'hD34, 32'hDEAD_BEEF, 4'd5},  // R5
        '{1'b0, 12'hD34, 32'hDEAD_BEEF, 4'd5},
        '{1'b1, 12'hD38, 32'h1234_5678, 4'd5},
        '{1'b0, 12'hD38, 32'h1234_5678, 4'd5},
        '{1'b1, 12'hD3C, 32'hFFFF_FFFF, 4'd8},  // R8 unmapped
        '{1'b0, 12'hD3C, 32'h0000_0000, 4'd8},
        '{1'b0, 12'hD34, 32'hDEAD_BEEF, 4'd8},
        '{1'b1, 12'hD14, 32'h0000_0000, 4'd2},
        '{1'b0, 12'hD14, 32'h0000_0000, 4'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0; bus_priv = 1'b0;
        #1;
    endtask

    task automatic read_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic trig_check(input logic [31:0] d, input logic p, input logic exp_v,
                              input logic [8:0] exp_irq, input string tag);
        bus_write(12'hF00, d, p);
        check({tag, " pulse"}, {31'b0, pend_valid}, {31'b0, exp_v});
        if (exp_v) check({tag, " irq"}, {23'b0, pend_irq}, {23'b0, exp_irq});
        @(negedge clk); #1;
        check({tag, " one cycle R9"}, {31'b0, pend_valid}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check(12'hD14, 32'h0, "R1 cfg");
        read_check(12'hD28, 32'h0, "R1 flt_cfg");
        read_check(12'hD2C, 32'h0, "R1 flt_hard");
        read_check(12'hD30, 32'h0, "R1 flt_dbg");
        read_check(12'hD34, 32'h0, "R1 mem_addr");
        read_check(12'hD38, 32'h0, "R1 bus_addr");
        check("R1 pend_valid", {31'b0, pend_valid}, 32'h0);

        // table walk: R2, R5, R8
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data, 1'b1);
            else read_check(VECS[i].addr, VECS[i].data, $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R4 hardware sets
        @(negedge clk);
        cfg_fault_set = 32'h0000_00A5; hard_fault_set = 32'h4000_0002; dbg_fault_set = 32'h0000_0001;
        @(negedge clk);
        cfg_fault_set = '0; hard_fault_set = '0; dbg_fault_set = '0;
        read_check(12'hD28, 32'h0000_00A5, "R4 set flt_cfg");
        read_check(12'hD2C, 32'h4000_0002, "R4 set flt_hard");
        read_check(12'hD30, 32'h0000_0001, "R4 set flt_dbg");

        // R3 write-one-to-clear
        bus_write(12'hD28, 32'h0000_0005, 1'b1);
        read_check(12'hD28, 32'h0000_00A0, "R3 clear flt_cfg");
        bus_write(12'hD2C, 32'h4000_0000, 1'b0);
        read_check(12'hD2C, 32'h0000_0002, "R3 clear flt_hard");
        bus_write(12'hD30, 32'h0000_0000, 1'b1);
        read_check(12'hD30, 32'h0000_0001, "R3 zero keeps flt_dbg");

        // R4 set beats simultaneous clear
        @(negedge clk);
        cfg_fault_set = 32'h0000_0080;
        bus_wen = 1'b1; bus_addr = 12'hD28; bus_wdata = 32'h0000_0080; bus_priv = 1'b1;
        @(negedge clk);
        cfg_fault_set = '0; bus_wen = 1'b0; bus_wdata = '0;
        read_check(12'hD28, 32'h0000_00A0, "R4 set wins");

        // R8 misaligned offset
        read_check(12'hD29, 32'h0, "R8 misaligned read");
        read_check(12'hF00, 32'h0, "R8 trigger reads zero");

        // R6 trigger range and truncation
        trig_check(32'h0000_0005, 1'b1, 1'b1, 9'd5,  "R6 irq5");
        trig_check(32'h0000_003F, 1'b1, 1'b1, 9'd63, "R6 irq63");
        trig_check(32'h0000_0040, 1'b1, 1'b0, 9'd0,  "R6 irq64 rejected");
        trig_check(32'hFFFF_FE07, 1'b1, 1'b1, 9'd7,  "R6 upper bits ignored");

        // R7 unprivileged gating
        trig_check(32'h0000_0003, 1'b0, 1'b0, 9'd0, "R7 user blocked");
        bus_write(12'hD14, 32'h0000_0002, 1'b1);
        trig_check(32'h0000_0003, 1'b0, 1'b1, 9'd3, "R7 user allowed");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule